// File: doc/BRIEF.md
# Length-Detecting Three-Wire Control Receiver

This block receives control frames over a three-wire serial link made of a serial clock, a data line and an enable line, all sampled by the chip's system clock. While enable is high, each falling edge of the serial clock shifts in one bit. The number of bits in a frame decides which output registers are loaded. A short frame changes only the four band-select bits. An 18-bit frame ended by enable loads a divider setting with a 9-bit main count. A frame that reaches its 19th bit loads a divider setting with a 10-bit main count. A 27-bit frame also loads an 8-bit test field.

A two-level mode input stands for a strap pin that is either tied low or left open. Together with the frame length, it picks the reference divider ratio that goes out with the divider setting. The main count (M), the swallow count (S), the ratio code and a flag that gives the width of the main count all load at the same moment, so the divider never sees a mixed setting.

Top module: `ctl3w_rx`

## Requirements
- R1: After synchronous reset the outputs are: band_out = 0, m_val = 0, s_val = 0, test_bits = 8'h01 (bit 0 set, so the tuning amplifier is off), ref_ratio = 2 (1/1024) and m_wide = 1.
- R2: A bit is taken from ser_dat on each falling edge of ser_clk while ser_en is high. The first bit of a frame is bit 1. On the 4th falling edge, band_out is loaded with bits 1 to 4, where bit 1 goes to band_out[3]. The load happens even while enable is still high.
- R3: If ser_en falls after exactly 18 bits and mode_open = 0, then m_val = {0, bits 5..13} (bit 5 is the MSB of the 9-bit count) and s_val = bits 14..18 (bit 14 is the MSB). At the same time ref_ratio becomes 0 (1/512) and m_wide becomes 0.
- R4: On the 19th falling edge of a frame, m_val is loaded with bits 5..14 and s_val with bits 15..19, and m_wide becomes 1. ref_ratio becomes 2 (1/1024) when mode_open = 0, or 1 (1/640) when mode_open = 1.
- R5: If enable falls before the count that loads the divider, only band_out can change, and only when at least 4 bits arrived. The required count is 18 when mode_open = 0 and 19 when mode_open = 1. m_val, s_val, ref_ratio, m_wide and test_bits keep their values.
- R6: Bits after the 19th do not change the divider outputs. On the 27th falling edge, test_bits is loaded with bits 20..27, where bit 20 goes to test_bits[7] and bit 27 goes to test_bits[0]. Clock edges after the 27th are ignored.
- R7: While ser_en is low, ser_clk and ser_dat edges change no output.
- R8: Every rising edge of ser_en starts a new frame at bit 1, whatever the length of the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Frame enable; high while a frame is sent |
| mode_open | input | 1 | Strap level: 0 means tied low, 1 means open |
| band_out | output | 4 | Band-select word |
| m_val | output | 10 | Main counter value |
| s_val | output | 5 | Swallow counter value |
| test_bits | output | 8 | Test field, in frame order |
| ref_ratio | output | 2 | Reference ratio code: 0 = 1/512, 1 = 1/640, 2 = 1/1024 |
| m_wide | output | 1 | 1 when the main count is 10 bits wide, 0 when it is 9 bits |

## Verification
The hardest case to reach from the ports is the split between an enable fall after exactly 18 bits and an enable fall one bit earlier or one bit later. The mode pin also moves that boundary, so each side must be tried with both mode levels. The bench builds frames whose length can be chosen bit by bit. It ends them at 17, 18, 19 and 22 bits and at 27 and 30 bits, and it sets the pin both ways, so that each path is reached on purpose. Distinct bit patterns in the band, count and test positions show any shift in field alignment.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    parameter int BAND_W  = 4;
    parameter int MW_WIDE = 10;
    parameter int S_W     = 5;
    parameter int TEST_W  = 8;

    localparam int MW_NARROW = MW_WIDE - 1;
    localparam int LEN_NARROW = BAND_W + MW_NARROW + S_W;   // 18
    localparam int LEN_WIDE   = BAND_W + MW_WIDE + S_W;     // 19
    localparam int LEN_FULL   = LEN_WIDE + TEST_W;          // 27
    localparam int CNT_W      = $clog2(LEN_FULL + 1);

    localparam logic [TEST_W-1:0] TEST_RESET = TEST_W'(1);

    typedef enum logic [1:0] {
        RATIO_512  = 2'd0,
        RATIO_640  = 2'd1,
        RATIO_1024 = 2'd2
    } ratio_e;

    typedef struct packed {
        logic                wide;
        ratio_e              ratio;
        logic [MW_WIDE-1:0]  m;
        logic [S_W-1:0]      s;
    } div_cfg_t;

    function automatic ratio_e wide_ratio(input logic strap_open);
        return strap_open ? RATIO_640 : RATIO_1024;
    endfunction

    function automatic div_cfg_t cfg_reset();
        div_cfg_t c;
        c.wide  = 1'b1;
        c.ratio = RATIO_1024;
        c.m     = '0;
        c.s     = '0;
        return c;
    endfunction
endpackage

// File: rtl/ctl3w_edges.sv
module ctl3w_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sen,
    output logic bit_evt,
    output logic en_rise,
    output logic en_fall
);
    logic sclk_q;
    logic sen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sen_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sen_q  <= sen;
        end
    end

    assign bit_evt = sclk_q & ~sclk & sen;
    assign en_rise = ~sen_q & sen;
    assign en_fall = sen_q & ~sen;
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_evt,
    input  logic                en_rise,
    input  logic                din,
    output logic                take_bit,
    output logic [CNT_W-1:0]    cnt,
    output logic [CNT_W-1:0]    cnt_nxt,
    output logic [LEN_FULL-1:0] sr,
    output logic [LEN_FULL-1:0] sr_nxt
);
    assign take_bit = bit_evt && (cnt < CNT_W'(LEN_FULL));
    assign cnt_nxt  = cnt + CNT_W'(1);
    assign sr_nxt   = {sr[LEN_FULL-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sr  <= '0;
        end else if (en_rise) begin
            cnt <= '0;
            sr  <= '0;
        end else if (take_bit) begin
            cnt <= cnt_nxt;
            sr  <= sr_nxt;
        end
    end
endmodule

// File: rtl/ctl3w_commit.sv
module ctl3w_commit
    import ctl3w_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take_bit,
    input  logic                en_fall,
    input  logic                strap_open,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W-1:0]    cnt_nxt,
    input  logic [LEN_FULL-1:0] sr,
    input  logic [LEN_FULL-1:0] sr_nxt,
    output logic [BAND_W-1:0]   band,
    output div_cfg_t            cfg,
    output logic [TEST_W-1:0]   test
);
    logic     at_band, at_wide, at_full, at_narrow;
    div_cfg_t cfg_wide, cfg_narrow;

    assign at_band   = take_bit && (cnt_nxt == CNT_W'(BAND_W));
    assign at_wide   = take_bit && (cnt_nxt == CNT_W'(LEN_WIDE));
    assign at_full   = take_bit && (cnt_nxt == CNT_W'(LEN_FULL));
    assign at_narrow = en_fall && !strap_open && (cnt == CNT_W'(LEN_NARROW));

    always_comb begin
        cfg_wide.wide  = 1'b1;
        cfg_wide.ratio = wide_ratio(strap_open);
        cfg_wide.m     = sr_nxt[S_W +: MW_WIDE];
        cfg_wide.s     = sr_nxt[S_W-1:0];

        cfg_narrow.wide  = 1'b0;
        cfg_narrow.ratio = RATIO_512;
        cfg_narrow.m     = {1'b0, sr[S_W +: MW_NARROW]};
        cfg_narrow.s     = sr[S_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            band <= '0;
            cfg  <= cfg_reset();
            test <= TEST_RESET;
        end else begin
            if (at_band)   band <= sr_nxt[BAND_W-1:0];
            if (at_wide)   cfg  <= cfg_wide;
            if (at_narrow) cfg  <= cfg_narrow;
            if (at_full)   test <= sr_nxt[TEST_W-1:0];
        end
    end
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_en,
    input  logic               mode_open,
    output logic [BAND_W-1:0]  band_out,
    output logic [MW_WIDE-1:0] m_val,
    output logic [S_W-1:0]     s_val,
    output logic [TEST_W-1:0]  test_bits,
    output logic [1:0]         ref_ratio,
    output logic               m_wide
);
    logic                bit_evt, en_rise, en_fall, take_bit;
    logic [CNT_W-1:0]    cnt, cnt_nxt;
    logic [LEN_FULL-1:0] sr, sr_nxt;
    div_cfg_t            cfg;

    ctl3w_edges u_edges (
        .clk     (clk),
        .rst     (rst),
        .sclk    (ser_clk),
        .sen     (ser_en),
        .bit_evt (bit_evt),
        .en_rise (en_rise),
        .en_fall (en_fall)
    );

    ctl3w_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_evt  (bit_evt),
        .en_rise  (en_rise),
        .din      (ser_dat),
        .take_bit (take_bit),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt),
        .sr       (sr),
        .sr_nxt   (sr_nxt)
    );

    ctl3w_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .take_bit   (take_bit),
        .en_fall    (en_fall),
        .strap_open (mode_open),
        .cnt        (cnt),
        .cnt_nxt    (cnt_nxt),
        .sr         (sr),
        .sr_nxt     (sr_nxt),
        .band       (band_out),
        .cfg        (cfg),
        .test       (test_bits)
    );

    assign m_val     = cfg.m;
    assign s_val     = cfg.s;
    assign ref_ratio = cfg.ratio;
    assign m_wide    = cfg.wide;
endmodule

// File: rtl/ctl3w_rx_chk.sv
module ctl3w_rx_chk
    import ctl3w_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ser_en,
    input logic [BAND_W-1:0]  band_out,
    input logic [MW_WIDE-1:0] m_val,
    input logic [S_W-1:0]     s_val,
    input logic [TEST_W-1:0]  test_bits,
    input logic [1:0]         ref_ratio,
    input logic               m_wide
);
    AST_NARROW_RATIO: assert property (@(posedge clk) disable iff (rst)
        !m_wide |-> ref_ratio == 2'd0);                                   // R3
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !m_wide |-> m_val[MW_WIDE-1] == 1'b0);                            // R3
    AST_WIDE_RATIO: assert property (@(posedge clk) disable iff (rst)
        m_wide |-> (ref_ratio == 2'd1 || ref_ratio == 2'd2));             // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && !$past(ser_en) && !$past(ser_en, 2)) |->
        ($stable(band_out) && $stable(m_val) && $stable(s_val) &&
         $stable(test_bits) && $stable(ref_ratio)));                      // R7
endmodule

bind ctl3w_rx ctl3w_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_en    (ser_en),
    .band_out  (band_out),
    .m_val     (m_val),
    .s_val     (s_val),
    .test_bits (test_bits),
    .ref_ratio (ref_ratio),
    .m_wide    (m_wide)
);

// File: tb/sim_ctl3w_rx.sv
module sim_ctl3w_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0, mode_open = 1'b0;
    logic [3:0] band_out;
    logic [9:0] m_val;
    logic [4:0] s_val;
    logic [7:0] test_bits;
    logic [1:0] ref_ratio;
    logic       m_wide;

    int checks = 0, errors = 0;
    logic [3:0] e_band;
    logic [9:0] e_m;
    logic [4:0] e_s;
    logic [7:0] e_test;
    logic [1:0] e_ratio;
    logic       e_wide;

    always #4 clk = ~clk;

    ctl3w_rx u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en(ser_en), .mode_open(mode_open), .band_out(band_out),
        .m_val(m_val), .s_val(s_val), .test_bits(test_bits),
        .ref_ratio(ref_ratio), .m_wide(m_wide)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "band", 32'(band_out), 32'(e_band));
        check(req, "m", 32'(m_val), 32'(e_m));
        check(req, "s", 32'(s_val), 32'(e_s));
        check(req, "test", 32'(test_bits), 32'(e_test));
        check(req, "ratio", 32'(ref_ratio), 32'(e_ratio));
        check(req, "wide", 32'(m_wide), 32'(e_wide));
    endtask

    task automatic en_up();
        @(negedge clk) ser_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic en_down();
        @(negedge clk) ser_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // word holds the bits MSB first: bit 1 of the frame is word[n-1]
    task automatic shift_bits(input logic [31:0] word, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) begin ser_dat = word[i]; ser_clk = 1'b1; end
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send(input logic [31:0] word, input int n);
        en_up();
        shift_bits(word, n);
        en_down();
    endtask

    task automatic t_reset();
        e_band = 0; e_m = 0; e_s = 0; e_test = 8'h01; e_ratio = 2; e_wide = 1;
        check_all("R1");
    endtask

    task automatic t_narrow();   // R3
        mode_open = 0;
        send({4'hA, 9'h1A5, 5'h13}, 18);
        e_band = 4'hA; e_m = 10'h1A5; e_s = 5'h13; e_ratio = 0; e_wide = 0;
        check_all("R3");
    endtask

    task automatic t_wide(input logic open);   // R4
        mode_open = open;
        send({4'h5, 10'h3C7, 5'h0C}, 19);
        e_band = 4'h5; e_m = 10'h3C7; e_s = 5'h0C; e_ratio = open ? 2'd1 : 2'd2; e_wide = 1;
        check_all("R4");
    endtask

    task automatic t_short(input logic open, input int n);   // R5
        logic [31:0] w;
        mode_open = open;
        w = {4'h9, 10'h2AA, 5'h1F} >> (19 - n);
        send(w, n);
        if (n >= 4) e_band = 4'h9;
        check_all("R5");
    endtask

    task automatic t_idle();   // R7
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) begin ser_dat = i[0]; ser_clk = 1'b1; end
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        check_all("R7");
    endtask

    task automatic t_band_early();   // R2: band loads at the 4th bit, enable still high
        mode_open = 0;
        en_up();
        shift_bits(32'h6, 4);
        e_band = 4'h6;
        check("R2", "band mid-frame", 32'(band_out), 32'(e_band));
        check("R2", "m mid-frame", 32'(m_val), 32'(e_m));
        en_down();
    endtask

    task automatic t_full(input int n);   // R6
        logic [31:0] w;
        mode_open = 1;
        w = {4'h3, 10'h155, 5'h0A, 8'hB6, 3'b101};
        send(w >> (30 - n), n);
        e_band = 4'h3; e_m = 10'h155; e_s = 5'h0A; e_ratio = 1; e_wide = 1;
        if (n >= 27) e_test = 8'hB6;
        check_all("R6");
    endtask

    task automatic t_restart();   // R8
        mode_open = 0;
        send(32'h2B, 7);
        e_band = 4'h5;
        send({4'hC, 10'h0F1, 5'h07}, 19);
        e_band = 4'hC; e_m = 10'h0F1; e_s = 5'h07; e_ratio = 2; e_wide = 1;
        check_all("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_narrow();
        t_short(0, 17);      // one short of 18 with strap low
        t_wide(0);
        t_short(1, 18);      // 18 bits with strap open is short
        t_wide(1);
        t_short(0, 3);       // below band length: nothing moves
        t_idle();
        t_band_early();
        t_full(22);          // enable falls between 19 and 27
        t_full(27);
        e_test = 8'h01;
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        t_reset();
        t_full(30);          // clocks past 27 ignored
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule